// File: doc/BRIEF.md
# Battery Gauge Status Flag Unit

This block holds the status byte of a battery fuel gauge. It takes comparator results on the battery sense voltage, strobes from the charge and discharge accounting logic, the self-discharge count, a below-freezing indication and the level of the charge-control pin. From these it sets, latches and clears six flags. Some flags follow a level directly. Others are latched until a specific event arrives. One of them is set only after a run of 64 charge events.

The unit also drives the first display segment. When the first low-battery warning is active, that segment blinks from a divided clock. When the final warning is active, all segments are blanked. All flags are registered. A flag reflects the inputs sampled at a clock edge from just after that edge. Reset is synchronous and active low.

Top module: `batt_flag_unit`

## Requirements
- R1: Flag bit 5 (battery absent) is 1 when `vs_below_min` or `vs_above_max` was high at the previous clock edge, and 0 otherwise.
- R2: Flag bit 4 (capacity doubtful) is 1 after reset. It becomes 1 on the 64th `chg_event` pulse that follows the last `cap_update`. Further pulses leave it at 1.
- R3: A `cap_update` pulse clears bit 4 and restarts the charge-event count from zero. If `cap_update` and `chg_event` occur in the same cycle, that charge event is not counted.
- R4: Flag bit 2 (valid discharge) is set by a `dsg_start` pulse while `acc_eq_cap` is high. It otherwise holds its value.
- R5: Bit 2 is cleared by any of three conditions: a `cap_update` pulse; `sdc_count` ≥ 4096; or bit 0 newly setting while `below_freeze` is high. Any clear condition wins over a set in the same cycle.
- R6: Bit 2 is also cleared once `chg_valid` has stayed high across 256 `acc_inc` pulses. The clear lands in the cycle after the 256th pulse is counted. Dropping `chg_valid` restarts this count from zero.
- R7: Flag bit 0 (first low warning) is set when `vs_below_warn` is high and `overload` is low. It stays set until `chg_valid` is high while `vs_below_warn` is low.
- R8: Flag bit 3 (final low warning) is set by `vs_below_final`. It stays set until `chg_valid` is seen with `vs_below_final` low. `seg_blank` equals bit 3.
- R9: Flag bit 1 (charge inhibited) is 1 when `chg_pin_hiz` was high at the previous edge, and 0 when it was low.
- R10: `seg1_on` = `disp_en` AND NOT bit 3 AND (NOT bit 0 OR blink phase). The blink phase is 1 after reset and toggles every `BLINK_DIV` clock edges.
- R11: Flag bits 7 and 6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vs_below_min | input | 1 | Sense voltage below 0.1 V |
| vs_above_max | input | 1 | Sense voltage above 2.25 V |
| vs_below_warn | input | 1 | Sense voltage below 1.05 V |
| vs_below_final | input | 1 | Sense voltage at final failure threshold |
| overload | input | 1 | Overload indication; blocks the first warning |
| chg_valid | input | 1 | Valid charge in progress (level) |
| chg_event | input | 1 | Valid charge action completed (pulse) |
| cap_update | input | 1 | Learned capacity updated (pulse) |
| dsg_start | input | 1 | Discharge begins (pulse) |
| acc_eq_cap | input | 1 | Available-charge register equals learned capacity |
| acc_inc | input | 1 | Available-charge count step (pulse) |
| sdc_count | input | SDC_W | Self-discharge count |
| below_freeze | input | 1 | Temperature below 0 °C |
| chg_pin_hiz | input | 1 | Charge-control pin is high-impedance |
| disp_en | input | 1 | Display enabled |
| flags | output | 8 | Status byte |
| seg1_on | output | 1 | Drive for the first display segment |
| seg_blank | output | 1 | Turn all segment drivers off |

## Verification
The bench runs exactly 63 charge events and then a 64th, so a counter that is off by one sets bit 4 one event early or late. It issues an update in the same cycle as a charge event; a design that counts that event trips bit 4 one event too early afterwards. For the valid-discharge flag, it drops `chg_valid` after 255 steps and then runs a full sustain. A design that kept the partial count would clear bit 2 early. The bench also raises the first warning at below-freezing temperature with a discharge set pending in the same cycle, which exposes a set-over-clear priority error. The blink, blanking and overload gating are compared on every clock against a behavioural model.

// File: rtl/batt_flag_pkg.sv
// Shared bit positions of the status byte.
package batt_flag_pkg;
    localparam int FLAG_W  = 8;
    localparam int B_EDV1  = 0;
    localparam int B_CHG   = 1;
    localparam int B_VDQ   = 2;
    localparam int B_EDVF  = 3;
    localparam int B_CI    = 4;
    localparam int B_BRM   = 5;
endpackage

// File: rtl/bf_charge_ctr.sv
// Counts valid charge events since the last capacity update.
// Emits a one-cycle hit when the event count reaches N_EVT.
// Assumes the strobes are single-cycle pulses.
module bf_charge_ctr #(
    parameter int N_EVT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic evt,
    output logic hit
);
    localparam int CW = $clog2(N_EVT + 1);
    logic [CW-1:0] cnt_q;

    // Saturating event counter, cleared on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt_q <= '0;
        else if (evt && cnt_q != CW'(N_EVT))
            cnt_q <= cnt_q + 1'b1;
    end

    // Hit on the event that brings the count to N_EVT.
    always_comb hit = evt && !restart && (cnt_q == CW'(N_EVT - 1));
endmodule

// File: rtl/bf_sustain_ctr.sv
// Counts accumulator steps while a valid charge continues.
// Asserts done once SUSTAIN steps have been counted.
// Assumes acc_inc is a single-cycle pulse.
module bf_sustain_ctr #(
    parameter int SUSTAIN = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic step,
    output logic done
);
    localparam int CW = $clog2(SUSTAIN + 1);
    logic [CW-1:0] cnt_q;

    // Step counter, cleared whenever the charge stops.
    always_ff @(posedge clk) begin
        if (!rst_n || !active)
            cnt_q <= '0;
        else if (step && cnt_q != CW'(SUSTAIN))
            cnt_q <= cnt_q + 1'b1;
    end

    // Level output once the sustain target is reached.
    always_comb done = (cnt_q == CW'(SUSTAIN));
endmodule

// File: rtl/bf_blink_div.sv
// Free-running divider producing a blink phase.
// The phase starts at 1 and toggles every DIV clock edges.
module bf_blink_div #(
    parameter int DIV = 6_250_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    logic [CW-1:0] cnt_q;

    // Divider count and phase toggle on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            phase <= 1'b1;
        end else if (cnt_q == CW'(DIV - 1)) begin
            cnt_q <= '0;
            phase <= ~phase;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/batt_flag_unit.sv
// Status flag unit of a battery fuel gauge.
// Sets, latches and clears six status flags from the comparator and
// accounting inputs, and drives the first segment blink and blanking.
// Assumes single-cycle strobes and inputs synchronous to clk.
module batt_flag_unit
    import batt_flag_pkg::*;
#(
    parameter int SDC_W      = 13,
    parameter int SDC_LIMIT  = 4096,
    parameter int CI_EVENTS  = 64,
    parameter int SUSTAIN    = 256,
    parameter int BLINK_DIV  = 6_250_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vs_below_min,
    input  logic             vs_above_max,
    input  logic             vs_below_warn,
    input  logic             vs_below_final,
    input  logic             overload,
    input  logic             chg_valid,
    input  logic             chg_event,
    input  logic             cap_update,
    input  logic             dsg_start,
    input  logic             acc_eq_cap,
    input  logic             acc_inc,
    input  logic [SDC_W-1:0] sdc_count,
    input  logic             below_freeze,
    input  logic             chg_pin_hiz,
    input  logic             disp_en,
    output logic [7:0]       flags,
    output logic             seg1_on,
    output logic             seg_blank
);
    logic brm_q, chg_q, ci_q, vdq_q, edv1_q, edvf_q;
    logic ci_hit, sus_done, phase;
    logic edv1_set, freeze_clr, vdq_clr, vdq_set;

    bf_charge_ctr #(.N_EVT(CI_EVENTS)) u_chg_ctr (
        .clk(clk), .rst_n(rst_n), .restart(cap_update),
        .evt(chg_event), .hit(ci_hit)
    );

    bf_sustain_ctr #(.SUSTAIN(SUSTAIN)) u_sus_ctr (
        .clk(clk), .rst_n(rst_n), .active(chg_valid),
        .step(acc_inc), .done(sus_done)
    );

    bf_blink_div #(.DIV(BLINK_DIV)) u_blink (
        .clk(clk), .rst_n(rst_n), .phase(phase)
    );

    // Set and clear terms for the discharge and warning flags.
    always_comb begin
        edv1_set   = vs_below_warn && !overload;
        freeze_clr = edv1_set && !edv1_q && below_freeze;
        vdq_clr    = cap_update || (sdc_count >= SDC_W'(SDC_LIMIT))
                     || sus_done || freeze_clr;
        vdq_set    = dsg_start && acc_eq_cap;
    end

    // Level flags following their inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brm_q <= 1'b0;
            chg_q <= 1'b0;
        end else begin
            brm_q <= vs_below_min || vs_above_max;
            chg_q <= chg_pin_hiz;
        end
    end

    // Capacity-doubtful flag: set by reset and by the event count.
    always_ff @(posedge clk) begin
        if (!rst_n)          ci_q <= 1'b1;
        else if (cap_update) ci_q <= 1'b0;
        else if (ci_hit)     ci_q <= 1'b1;
    end

    // Valid-discharge flag with clear over set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       vdq_q <= 1'b0;
        else if (vdq_clr) vdq_q <= 1'b0;
        else if (vdq_set) vdq_q <= 1'b1;
    end

    // Latched low-voltage warnings, released by a valid charge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edv1_q <= 1'b0;
            edvf_q <= 1'b0;
        end else begin
            if (edv1_set)                         edv1_q <= 1'b1;
            else if (chg_valid && !vs_below_warn) edv1_q <= 1'b0;
            if (vs_below_final)                   edvf_q <= 1'b1;
            else if (chg_valid)                   edvf_q <= 1'b0;
        end
    end

    // Assemble the status byte.
    always_comb begin
        flags         = '0;
        flags[B_EDV1] = edv1_q;
        flags[B_CHG]  = chg_q;
        flags[B_VDQ]  = vdq_q;
        flags[B_EDVF] = edvf_q;
        flags[B_CI]   = ci_q;
        flags[B_BRM]  = brm_q;
    end

    // Segment drive: blink under first warning, blank under final.
    always_comb begin
        seg_blank = edvf_q;
        seg1_on   = disp_en && !edvf_q && (!edv1_q || phase);
    end
endmodule

// File: rtl/batt_flag_unit_chk.sv
// Temporal checks on the status flag unit, attached by bind.
module batt_flag_unit_chk #(
    parameter int SDC_W     = 13,
    parameter int SDC_LIMIT = 4096
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vs_below_min,
    input logic             vs_above_max,
    input logic             vs_below_warn,
    input logic             vs_below_final,
    input logic             overload,
    input logic             chg_valid,
    input logic             cap_update,
    input logic [SDC_W-1:0] sdc_count,
    input logic             chg_pin_hiz,
    input logic [7:0]       flags,
    input logic             seg1_on
);
    AST_BRM_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_below_min || vs_above_max) |=> flags[5]);                 // R1
    AST_CI_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        cap_update |=> !flags[4]);                                    // R3
    AST_VDQ_SDC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (sdc_count >= SDC_W'(SDC_LIMIT)) |=> !flags[2]);              // R5
    AST_EDV1_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !chg_valid) |=> flags[0]);                       // R7
    AST_EDV1_OVLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags[0] && (overload || !vs_below_warn)) |=> !flags[0]);   // R7
    AST_EDVF_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_below_final || (flags[3] && !chg_valid)) |=> flags[3]);   // R8
    AST_EDVF_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        flags[3] |-> !seg1_on);                                       // R10
    AST_CHG_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        chg_pin_hiz |=> flags[1]);                                    // R9
    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        flags[7:6] == 2'b00);                                         // R11
endmodule

bind batt_flag_unit batt_flag_unit_chk #(.SDC_W(SDC_W), .SDC_LIMIT(SDC_LIMIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .vs_below_min(vs_below_min),
    .vs_above_max(vs_above_max), .vs_below_warn(vs_below_warn),
    .vs_below_final(vs_below_final), .overload(overload),
    .chg_valid(chg_valid), .cap_update(cap_update), .sdc_count(sdc_count),
    .chg_pin_hiz(chg_pin_hiz), .flags(flags), .seg1_on(seg1_on)
);

// File: tb/test_batt_flag_unit.sv
module test_batt_flag_unit;
    localparam int SDC_W = 13;
    localparam int DIV   = 5;
    localparam int SUS   = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vs_below_min = 0, vs_above_max = 0, vs_below_warn = 0, vs_below_final = 0;
    logic overload = 0, chg_valid = 0, chg_event = 0, cap_update = 0;
    logic dsg_start = 0, acc_eq_cap = 0, acc_inc = 0, below_freeze = 0;
    logic chg_pin_hiz = 0, disp_en = 0;
    logic [SDC_W-1:0] sdc_count = '0;
    logic [7:0] flags;
    logic seg1_on, seg_blank;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    batt_flag_unit #(.SDC_W(SDC_W), .BLINK_DIV(DIV)) i_batt_flag_unit (
        .clk(clk), .rst_n(rst_n), .vs_below_min(vs_below_min),
        .vs_above_max(vs_above_max), .vs_below_warn(vs_below_warn),
        .vs_below_final(vs_below_final), .overload(overload),
        .chg_valid(chg_valid), .chg_event(chg_event), .cap_update(cap_update),
        .dsg_start(dsg_start), .acc_eq_cap(acc_eq_cap), .acc_inc(acc_inc),
        .sdc_count(sdc_count), .below_freeze(below_freeze),
        .chg_pin_hiz(chg_pin_hiz), .disp_en(disp_en), .flags(flags),
        .seg1_on(seg1_on), .seg_blank(seg_blank)
    );

    // Behavioural reference model
    bit m_brm, m_chg, m_ci, m_vdq, m_edv1, m_edvf;
    int m_events, m_sustain, m_edges;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_brm = 0; m_chg = 0; m_ci = 1; m_vdq = 0; m_edv1 = 0; m_edvf = 0;
            m_events = 0; m_sustain = 0; m_edges = 0;
        end else begin
            bit sus_was_done, e1_set, clr;
            sus_was_done = (m_sustain == SUS);
            e1_set = vs_below_warn && !overload;
            m_brm = vs_below_min || vs_above_max;
            m_chg = chg_pin_hiz;
            if (cap_update) begin
                m_ci = 0; m_events = 0;
            end else if (chg_event && m_events < 64) begin
                m_events++;
                if (m_events == 64) m_ci = 1;
            end
            clr = cap_update || (int'(sdc_count) >= 4096) || sus_was_done
                  || (e1_set && !m_edv1 && below_freeze);
            if (clr) m_vdq = 0;
            else if (dsg_start && acc_eq_cap) m_vdq = 1;
            if (!chg_valid) m_sustain = 0;
            else if (acc_inc && m_sustain < SUS) m_sustain++;
            if (e1_set) m_edv1 = 1;
            else if (chg_valid && !vs_below_warn) m_edv1 = 0;
            if (vs_below_final) m_edvf = 1;
            else if (chg_valid) m_edvf = 0;
            m_edges++;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the clock edges
    always @(negedge clk) begin
        #2;
        if (rst_n && !finished) begin
            bit ph, s1;
            ph = ((m_edges / DIV) % 2) == 0;
            s1 = disp_en && !m_edvf && (!m_edv1 || ph);
            check(flags[5] == m_brm,  "R1 brm",  flags[5], m_brm);
            check(flags[4] == m_ci,   "R2/R3 ci", flags[4], m_ci);
            check(flags[2] == m_vdq,  "R4/R5/R6 vdq", flags[2], m_vdq);
            check(flags[0] == m_edv1, "R7 edv1", flags[0], m_edv1);
            check(flags[3] == m_edvf, "R8 edvf", flags[3], m_edvf);
            check(seg_blank == m_edvf, "R8 blank", seg_blank, m_edvf);
            check(flags[1] == m_chg,  "R9 chg",  flags[1], m_chg);
            check(seg1_on == s1,      "R10 seg1", seg1_on, s1);
            check(flags[7:6] == 2'b00, "R11 spare", flags[7:6], 0);
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic look(bit ok, string req, int act, int exp);
        #3;
        check(ok, req, act, exp);
    endtask

    task automatic charge_events(int n);
        for (int i = 0; i < n; i++) begin
            chg_event = 1; tick(); chg_event = 0; tick();
        end
    endtask

    task automatic arm_vdq();
        acc_eq_cap = 1; dsg_start = 1; tick(); dsg_start = 0; acc_eq_cap = 0; tick();
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        tick();
        look(flags == 8'h10, "R2 reset state", flags, 8'h10);

        // R1 and R9 level flags
        vs_below_min = 1; tick(); look(flags[5] == 1, "R1 low", flags[5], 1);
        vs_below_min = 0; vs_above_max = 1; tick(2);
        vs_above_max = 0; tick(); look(flags[5] == 0, "R1 in range", flags[5], 0);
        chg_pin_hiz = 1; tick(); look(flags[1] == 1, "R9 hiz", flags[1], 1);
        chg_pin_hiz = 0; tick(); look(flags[1] == 0, "R9 driven", flags[1], 0);

        // R2/R3 charge counting
        cap_update = 1; tick(); cap_update = 0;
        look(flags[4] == 0, "R3 clear", flags[4], 0);
        charge_events(63);
        look(flags[4] == 0, "R2 after 63", flags[4], 0);
        charge_events(1);
        look(flags[4] == 1, "R2 after 64", flags[4], 1);
        charge_events(3);
        cap_update = 1; chg_event = 1; tick(); cap_update = 0; chg_event = 0;
        look(flags[4] == 0, "R3 same cycle", flags[4], 0);
        charge_events(63);
        look(flags[4] == 0, "R3 event dropped", flags[4], 0);
        charge_events(1);

        // R4/R5 valid discharge
        dsg_start = 1; tick(); dsg_start = 0;
        look(flags[2] == 0, "R4 needs compare", flags[2], 0);
        arm_vdq();
        look(flags[2] == 1, "R4 set", flags[2], 1);
        sdc_count = 13'd4095; tick(2);
        look(flags[2] == 1, "R5 below limit", flags[2], 1);
        sdc_count = 13'd4096; tick(); sdc_count = '0;
        look(flags[2] == 0, "R5 sdc limit", flags[2], 0);
        arm_vdq();
        cap_update = 1; acc_eq_cap = 1; dsg_start = 1; tick();
        cap_update = 0; acc_eq_cap = 0; dsg_start = 0;
        look(flags[2] == 0, "R5 clear wins", flags[2], 0);

        // R6 sustained charge
        arm_vdq();
        chg_valid = 1;
        for (int i = 0; i < 255; i++) begin acc_inc = 1; tick(); acc_inc = 0; end
        chg_valid = 0; tick();
        look(flags[2] == 1, "R6 partial", flags[2], 1);
        chg_valid = 1;
        for (int i = 0; i < 256; i++) begin acc_inc = 1; tick(); acc_inc = 0; end
        look(flags[2] == 1, "R6 one cycle later", flags[2], 1);
        tick(); chg_valid = 0;
        look(flags[2] == 0, "R6 cleared", flags[2], 0);

        // R7 overload gating, freeze clear of R5, latch
        disp_en = 1;
        vs_below_warn = 1; overload = 1; tick(2);
        look(flags[0] == 0, "R7 overload", flags[0], 0);
        arm_vdq();
        overload = 0; below_freeze = 1; acc_eq_cap = 1; dsg_start = 1; tick();
        acc_eq_cap = 0; dsg_start = 0;
        look(flags[2] == 0 && flags[0] == 1, "R5 freeze", flags[2], 0);
        below_freeze = 0;
        arm_vdq();
        look(flags[2] == 1, "R5 freeze only on rise", flags[2], 1);
        vs_below_warn = 0; tick(4 * DIV);
        look(flags[0] == 1, "R7 latched", flags[0], 1);
        chg_valid = 1; vs_below_warn = 1; tick();
        look(flags[0] == 1, "R7 held while low", flags[0], 1);
        vs_below_warn = 0; tick(); chg_valid = 0;
        look(flags[0] == 0, "R7 released", flags[0], 0);

        // R8 final warning and blanking
        vs_below_final = 1; tick(); vs_below_final = 0;
        look(seg_blank == 1 && seg1_on == 0, "R8 blank", seg_blank, 1);
        tick(3);
        chg_valid = 1; vs_below_final = 1; tick(); vs_below_final = 0;
        look(flags[3] == 1, "R8 set wins", flags[3], 1);
        tick(); chg_valid = 0;
        look(flags[3] == 0, "R8 released", flags[3], 0);
        disp_en = 0; tick(2);
        look(seg1_on == 0, "R10 display off", seg1_on, 0);

        tick(2);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule